// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block connects an internal requester to an external asynchronous bus whose responding ports can be 16 or 32 bits wide. The requester hands over one operand at a time, either a long word (four bytes) or a word (two bytes), together with its address and direction. The block runs bus cycles on the external side. Each cycle passes through three phases: address set-up, strobes asserted, and acknowledge wait. The responding port states its width on two active-low acknowledge lines in every cycle. When only the high acknowledge line answers, the port is 16 bits wide. The block then lowers its remaining-byte count by two, moves the address on by two, and starts a second cycle by itself. When both lines answer, the port is 32 bits wide and one cycle moves the whole operand.

The data bus has 32 lanes. A 16-bit port connects to lanes 15:0: the more significant byte of each pair sits on lanes 15:8 and the other on lanes 7:0. A 32-bit port uses the extension lanes 31:16 for the second byte pair of a long word. Read bytes are gathered into a 32-bit result. Byte 0 lands in bits 31:24 for a long word. A word result is returned in bits 15:0 with bits 31:16 zero.

Both requester interfaces are valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block has no operand in progress, so a requester holding `req_valid` simply waits. The result is presented with `rsp_valid` and held unchanged until a clock edge where `rsp_ready` is high. The block accepts no new request before then, so a slow consumer stalls the whole block rather than losing data.

Top module: `dyn_bus_master`

## Requirements
- R1: During and after reset, with no request, `bus_as_n` and `bus_ds_n` are 1, `req_ready` is 1, `rsp_valid` is 0, and the block does not drive `bus_data`.
- R2: The first bus cycle of a request drives `bus_addr` equal to the request address and `bus_rw` equal to 1 for a read and 0 for a write. For a long word it drives `bus_siz` = 2'b00, the four-byte code. Address, size and direction stay stable while `bus_as_n` is 0.
- R3: When a long-word cycle is ended by `ack_hi_n`=0 with `ack_lo_n`=1 (16-bit port), the block negates both strobes and then runs exactly one more cycle with no new request. That cycle has address + 2 and `bus_siz` = 2'b10, the two-byte code. `rsp_valid` rises only after the last cycle, with the strobes negated.
- R4: On a long-word read from a 16-bit port, first-cycle lanes 15:8 and 7:0 become result bits 31:24 and 23:16. Second-cycle lanes 15:0 become result bits 15:0.
- R5: On a long-word write to a 16-bit port, the first cycle drives request data bits 31:16 on lanes 15:0, and the second cycle drives bits 15:0 on lanes 15:0.
- R6: A long-word cycle ended by both acknowledge lines at 0 (32-bit port) is the only cycle of the request. On a read, lanes 15:0 give result bits 31:16 and lanes 31:16 give result bits 15:0. On a write, bits 31:16 go out on lanes 15:0 and bits 15:0 on lanes 31:16.
- R7: A word request uses `bus_siz` = 2'b10 and finishes in one cycle for either port width. A read returns lanes 15:0 in result bits 15:0, with bits 31:16 zero. A write drives request bits 15:0 on lanes 15:0.
- R8: `req_ready` is 0 from the accepting edge until the response is taken. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is 0.
- R9: The acknowledge inputs pass through two synchronizing flops. After an acknowledge appears, the strobes stay asserted for exactly three more falling clock edges.
- R10: Before starting a follow-up cycle, the block waits until both synchronized acknowledge lines have returned to 1. If the slave releases the acknowledge together with the strobe negation, three falling edges pass with `bus_as_n` at 1 before the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = long word (4 bytes), 0 = word (2 bytes) |
| req_addr | input | ADDR_W | Operand address |
| req_wdata | input | 32 | Write operand; a word uses bits 15:0 |
| rsp_valid | output | 1 | Transfer finished, result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_rdata | output | 32 | Assembled read result |
| bus_addr | output | ADDR_W | External address |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_siz | output | 2 | Remaining size: 00 four bytes, 01 one, 10 two, 11 three |
| bus_data | inout | 32 | Data lanes; 15:0 for 16-bit ports, 31:16 extension for 32-bit ports |
| ack_lo_n | input | 1 | Low acknowledge line, active low |
| ack_hi_n | input | 1 | High acknowledge line, active low |

## Verification
A wrong remaining-byte count or port decode shows up as a wrong number of strobe assertions, or as a wrong size code on the follow-up cycle, within one bus cycle of the acknowledge. A wrong address increment or lane choice shows on `bus_addr` or `bus_data` in the second cycle. It also appears in the assembled result when `rsp_valid` rises, a few cycles later. A synchronizer with a missing stage, or a sequencer that skips the release wait, changes the number of falling edges the strobes are held or negated. That count is measured on each cycle.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned OPW      = 32;
  localparam int unsigned HALFW    = OPW / 2;
  localparam int unsigned REM_W    = 3;
  localparam logic [REM_W-1:0] REM_LONG = 3'd4;
  localparam logic [REM_W-1:0] REM_WORD = 3'd2;
  localparam logic [1:0] SIZ_FOUR  = 2'b00;
  localparam logic [1:0] SIZ_TWO   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_RELEASE,
    ST_DONE
  } dbm_state_e;

  typedef enum logic [1:0] {
    PORT_NONE,
    PORT_16,
    PORT_32
  } dbm_port_e;

  function automatic dbm_port_e decode_port(input logic [1:0] ack_n);
    // ack_n[1] = high line, ack_n[0] = low line
    case (ack_n)
      2'b00:   return PORT_32;
      2'b01:   return PORT_16;
      default: return PORT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dbm_ack_sync.sv
module dbm_ack_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_n,
  output logic [W-1:0] sync_n
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= async_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/dbm_seq.sv
module dbm_seq
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_long,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  input  logic [1:0]        ack_sync_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic [1:0]        bus_siz,
  output logic              load,
  output logic              cap_en,
  output logic              cap_first,
  output logic              cap_wide,
  output logic              drv_en,
  output logic              drv_first
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  dbm_state_e       state;
  logic [REM_W-1:0] remain;
  logic [ADDR_W-1:0] cur_addr;
  logic             cur_rd;
  dbm_port_e        port;
  logic             strobes_on;

  assign port       = decode_port(ack_sync_n);
  assign strobes_on = (state == ST_STROBE) || (state == ST_WAIT);
  assign load       = (state == ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      cur_addr <= '0;
      cur_rd   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_rd   <= !req_write;
          remain   <= req_long ? REM_LONG : REM_WORD;
          state    <= ST_SETUP;
        end
        ST_SETUP:  state <= ST_STROBE;
        ST_STROBE: state <= ST_WAIT;
        ST_WAIT: if (port != PORT_NONE) begin
          if (port == PORT_32 || remain == REM_WORD) remain <= '0;
          else remain <= remain - REM_WORD;
          cur_addr <= cur_addr + STEP;
          state    <= ST_RELEASE;
        end
        ST_RELEASE: if (ack_sync_n == 2'b11) begin
          state <= (remain == '0) ? ST_DONE : ST_SETUP;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign bus_addr  = cur_addr;
  assign bus_rw    = cur_rd;
  assign bus_as_n  = !strobes_on;
  assign bus_ds_n  = !strobes_on;
  assign bus_siz   = (remain == REM_LONG) ? SIZ_FOUR : SIZ_TWO;

  assign cap_en    = (state == ST_WAIT) && (port != PORT_NONE) && cur_rd;
  assign cap_first = (remain == REM_LONG);
  assign cap_wide  = (port == PORT_32);
  assign drv_en    = strobes_on && !cur_rd;
  assign drv_first = (remain == REM_LONG);
endmodule

// File: rtl/dbm_lanes.sv
module dbm_lanes
  import dbm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [OPW-1:0] req_wdata,
  input  logic           cap_en,
  input  logic           cap_first,
  input  logic           cap_wide,
  input  logic [OPW-1:0] bus_in,
  input  logic           drv_first,
  output logic [OPW-1:0] drv_data,
  output logic [OPW-1:0] rdata
);
  logic [OPW-1:0] wbuf;
  logic [OPW-1:0] gather;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf   <= '0;
      gather <= '0;
    end else if (load) begin
      wbuf   <= req_wdata;
      gather <= '0;
    end else if (cap_en) begin
      if (cap_first) begin
        gather[OPW-1:HALFW] <= bus_in[HALFW-1:0];
        if (cap_wide) gather[HALFW-1:0] <= bus_in[OPW-1:HALFW];
      end else begin
        gather[HALFW-1:0] <= bus_in[HALFW-1:0];
      end
    end
  end

  always_comb begin
    if (drv_first) drv_data = {wbuf[HALFW-1:0], wbuf[OPW-1:HALFW]};
    else           drv_data = {{HALFW{1'b0}}, wbuf[HALFW-1:0]};
  end

  assign rdata = gather;
endmodule

// File: rtl/dyn_bus_master.sv
module dyn_bus_master
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_long,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic [1:0]        bus_siz,
  inout  wire  [31:0]       bus_data,
  input  logic              ack_lo_n,
  input  logic              ack_hi_n
);
  logic [1:0]     ack_sync_n;
  logic           load, cap_en, cap_first, cap_wide, drv_en, drv_first;
  logic [OPW-1:0] drv_data;

  dbm_ack_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n ({ack_hi_n, ack_lo_n}),
    .sync_n  (ack_sync_n)
  );

  dbm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_long   (req_long),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .ack_sync_n (ack_sync_n),
    .bus_addr   (bus_addr),
    .bus_rw     (bus_rw),
    .bus_as_n   (bus_as_n),
    .bus_ds_n   (bus_ds_n),
    .bus_siz    (bus_siz),
    .load       (load),
    .cap_en     (cap_en),
    .cap_first  (cap_first),
    .cap_wide   (cap_wide),
    .drv_en     (drv_en),
    .drv_first  (drv_first)
  );

  dbm_lanes u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .req_wdata (req_wdata),
    .cap_en    (cap_en),
    .cap_first (cap_first),
    .cap_wide  (cap_wide),
    .bus_in    (bus_data),
    .drv_first (drv_first),
    .drv_data  (drv_data),
    .rdata     (rsp_rdata)
  );

  assign bus_data = drv_en ? drv_data : 32'hzzzz_zzzz;
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rw,
  input logic              bus_as_n,
  input logic              bus_ds_n,
  input logic [1:0]        bus_siz
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_siz) && $stable(bus_rw))); // R2

  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> (bus_siz[0] == 1'b0)); // R7

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> !req_ready); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_as_n && bus_ds_n)); // R3
endmodule

bind dyn_bus_master dbm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .bus_addr  (bus_addr),
  .bus_rw    (bus_rw),
  .bus_as_n  (bus_as_n),
  .bus_ds_n  (bus_ds_n),
  .bus_siz   (bus_siz)
);

// File: tb/sim_dyn_bus_master.sv
module sim_dyn_bus_master;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int NV = 7;
  // {write, long, port32, addr[31:0], wdata[31:0], cycles[3:0]}
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_0000, 4'd2},
    {1'b0, 1'b1, 1'b1, 32'h0000_2004, 32'h0000_0000, 4'd1},
    {1'b0, 1'b0, 1'b0, 32'h0000_300A, 32'h0000_0000, 4'd1},
    {1'b1, 1'b1, 1'b0, 32'h0000_4000, 32'h1122_3344, 4'd2},
    {1'b1, 1'b1, 1'b1, 32'h0000_5008, 32'hA1B2_C3D4, 4'd1},
    {1'b1, 1'b0, 1'b0, 32'h0000_600C, 32'h0000_BEEF, 4'd1},
    {1'b0, 1'b0, 1'b1, 32'h0000_7002, 32'h0000_0000, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, bus_rw, bus_as_n, bus_ds_n;
  logic [31:0] rsp_rdata, bus_addr;
  logic [1:0]  bus_siz;
  wire  [31:0] bus_data;
  logic        ack_lo_n = 1'b1, ack_hi_n = 1'b1;

  logic        slv_drive = 1'b0, slv_p32 = 1'b0;
  logic [31:0] slv_data = '0;
  int          s_n = 0, s_lat = 0, s_gap = 0;
  logic [31:0] s_addr [2];
  logic [31:0] s_wd   [2];
  logic [1:0]  s_siz  [2];
  logic        s_rw   [2];
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_data = slv_drive ? slv_data : 32'hzzzz_zzzz;

  dyn_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_long(req_long), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_siz(bus_siz),
    .bus_data(bus_data), .ack_lo_n(ack_lo_n), .ack_hi_n(ack_hi_n)
  );

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // slave model: records each strobe assertion, answers one falling edge later
  initial begin
    int gapc = 0;
    forever begin
      @(negedge clk);
      if (bus_as_n) begin
        gapc++;
      end else begin
        int idx;
        int lat;
        if (s_n == 1) s_gap = gapc;
        idx = (s_n < 2) ? s_n : 1;
        s_addr[idx] = bus_addr;
        s_siz[idx]  = bus_siz;
        s_rw[idx]   = bus_rw;
        s_wd[idx]   = bus_data;
        s_n++;
        @(negedge clk);
        slv_data  = {pat(bus_addr + 32'd2), pat(bus_addr)};
        slv_drive = bus_rw;
        ack_hi_n  = 1'b0;
        ack_lo_n  = slv_p32 ? 1'b0 : 1'b1;
        lat = 0;
        do begin
          @(negedge clk);
          lat++;
        end while (!bus_as_n);
        s_lat     = lat;
        slv_drive = 1'b0;
        ack_hi_n  = 1'b1;
        ack_lo_n  = 1'b1;
        gapc = 0;
      end
    end
  end

  task automatic run(input logic wr, input logic lng, input logic p32,
                     input logic [31:0] a, input logic [31:0] wd, input int ncyc);
    int t;
    logic [31:0] exp_r;
    logic [31:0] held;
    @(negedge clk);
    s_n = 0;
    slv_p32 = p32;
    chk("R8 ready idle", 32'(req_ready), 32'd1);
    req_write = wr; req_long = lng; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready busy", 32'(req_ready), 32'd0);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk("R3 cycles", 32'(s_n), 32'(ncyc));
    chk("R2 addr first", s_addr[0], a);
    chk("R2 rw", 32'(s_rw[0]), 32'(!wr));
    chk("R2 R7 size first", 32'(s_siz[0]), lng ? 32'd0 : 32'd2);
    chk("R9 ack hold", 32'(s_lat), 32'd3);
    if (ncyc == 2) begin
      chk("R3 addr second", s_addr[1], a + 32'd2);
      chk("R3 size second", 32'(s_siz[1]), 32'd2);
      chk("R10 gap", 32'(s_gap), 32'd3);
    end
    if (!wr) begin
      if (lng) exp_r = {pat(a), pat(a + 32'd2)};
      else     exp_r = {16'h0000, pat(a)};
      chk(lng ? (p32 ? "R6 read" : "R4 read") : "R7 read", rsp_rdata, exp_r);
    end else if (lng && !p32) begin
      chk("R5 write first", 32'(s_wd[0][15:0]), 32'(wd[31:16]));
      chk("R5 write second", 32'(s_wd[1][15:0]), 32'(wd[15:0]));
    end else if (lng) begin
      chk("R6 write", s_wd[0], {wd[15:0], wd[31:16]});
    end else begin
      chk("R7 write", 32'(s_wd[0][15:0]), 32'(wd[15:0]));
    end
    held = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 rsp held", 32'(rsp_valid), 32'd1);
      chk("R8 data held", rsp_rdata, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 rsp taken", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 as reset", 32'(bus_as_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 as idle", 32'(bus_as_n), 32'd1);
    chk("R1 ds idle", 32'(bus_ds_n), 32'd1);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 rsp", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][70], VEC[i][69], VEC[i][68], VEC[i][67:36], VEC[i][35:4], int'(VEC[i][3:0]));
    end
    // directed corners: all-ones and all-zero data patterns, back to back
    run(1'b1, 1'b1, 1'b0, 32'h0000_FFFC, 32'hFFFF_0000, 2);
    run(1'b0, 1'b1, 1'b0, 32'h0000_5A3C, 32'h0000_0000, 2);
    run(1'b1, 1'b0, 1'b1, 32'h0000_0002, 32'h0000_8001, 1);
    repeat (4) @(negedge clk);
    chk("R1 quiet after", 32'(bus_as_n), 32'd1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule